// File: doc/BRIEF.md
# Dual-Width ALU with Status Flags

This block is the arithmetic and logic stage of a 16-bit datapath. On each accepted operation it combines two operands under a 4-bit opcode and returns a registered result together with a registered five-bit status word. The status word holds negative, zero, carry, overflow and sign-extension flags. A byte-mode select narrows the arithmetic to the low eight bits. In that mode every flag is taken from the low byte, and the upper result byte is taken unchanged from operand A.

A carry-in input lets software build add and subtract chains wider than one word. Carry and overflow are produced for every add and subtract, so both unsigned and signed branch tests can be made. A shadow register beside the flag word lets a controller save the flags on interrupt entry and restore them on return.

Top module: `alu_flags_unit`

## Requirements
- R1: The opcodes are ADD=0, ADDC=1, SUB=2, SUBC=3, AND=4, OR=5, XOR=6, CMP=7, MOV=8 and SEXT=9. The flag word bits are N=bit0, Z=bit1, C=bit2, V=bit3 and X=bit4. After an accepted word-mode ADD or SUB, the result and flags appear one clock later. C is the carry out of the top bit for an add and the borrow for a subtract (1 when A < B unsigned).
- R2: ADDC adds carry_in to A+B. SUBC subtracts carry_in as an extra borrow. ADD and SUB ignore carry_in.
- R3: V is set when an add or subtract overflows in two's complement at the active width.
- R4: In byte mode (byte_mode=1, all opcodes except SEXT), N is result bit 7, C comes from bit 7, and V is judged from bits 7 and 6. Z tests only bits 7..0. Result bits 15..8 equal operand A bits 15..8.
- R5: AND, OR and XOR set N and Z from the result and clear C, V and X.
- R6: CMP sets the flags as SUB would and leaves the result output unchanged.
- R7: MOV passes operand B as the result (in byte mode its low byte only). It sets N and Z from that result and clears C, V and X.
- R8: SEXT ignores byte_mode. It outputs B[7] copied into bits 15..8 above B[7:0], sets N and Z from the 16-bit result, clears C and V, and sets X to B[7]. Every other opcode clears X.
- R9: Neither the result nor the flags change when op_valid is 0, or when the opcode is 10 to 15.
- R10: flag_save copies the flag word into the shadow register. flag_restore loads the shadow into the flag word one clock later and overrides any operation issued in the same cycle. Asserting both swaps the two values.
- R11: Synchronous reset clears the result, the flags and the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept the operation this cycle |
| op_code | input | 4 | Operation select |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| carry_in | input | 1 | Carry or borrow from an earlier partial result |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| flag_save | input | 1 | Copy flags into the shadow |
| flag_restore | input | 1 | Load flags from the shadow |
| result | output | 16 | Registered result |
| flags | output | 5 | Registered flag word {X,V,C,Z,N} |

## Verification
The bench builds the block with the default 16-bit width, so the byte lane is 8 bits wide. This width makes the bit-7 and bit-6 carry and overflow boundaries and the pass-through of the upper byte observable. The operand corners are 0x7F/0x80, 0x7FFF/0x8000 and 0xFFFF, and they are exercised with carry-in and borrow-in both set and clear. A pseudo-random run mixes every opcode, both widths, invalid opcodes, idle cycles and save/restore pulses, and compares each cycle against a behavioural model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMP  = 4'd7,
    OP_MOV  = 4'd8,
    OP_SEXT = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic sx;
    logic ov;
    logic cy;
    logic zr;
    logic ng;
  } alu_flags_t;

  localparam int FLAG_BITS = $bits(alu_flags_t);
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ov
);
  logic [W-1:0] b_eff;
  logic [W:0]   ext;
  logic         c0;

  always_comb begin
    b_eff = sub ? ~b : b;
    c0    = sub ? ~cin : cin;
    ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    sum   = ext[W-1:0];
    cy    = sub ? ~ext[W] : ext[W];
    ov    = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_flag_bank.sv
module alu_flag_bank #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [NF-1:0] upd_val,
  input  logic          save,
  input  logic          restore,
  output logic [NF-1:0] flags_q,
  output logic [NF-1:0] shadow_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      shadow_q <= '0;
    end else begin
      if (save) shadow_q <= flags_q;
      if (restore) flags_q <= shadow_q;
      else if (upd) flags_q <= upd_val;
    end
  end

  // R10: restore loads the shadow, even when an operation is issued
  p_restore_r10: assert property (@(posedge clk) disable iff (rst)
    restore |=> flags_q == $past(shadow_q));
  // R10: the shadow follows a save
  p_save_r10: assert property (@(posedge clk) disable iff (rst)
    save |=> shadow_q == $past(flags_q));
  // R9: nothing changes without an update or a restore
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!upd && !restore) |=> $stable(flags_q));
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic             byte_mode,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             flag_save,
  input  logic             flag_restore,
  output logic [WIDTH-1:0] result,
  output logic [4:0]       flags
);
  import alu_pkg::*;

  localparam int HALF = WIDTH / 2;
  localparam int NF   = FLAG_BITS;

  alu_op_e op;
  logic    is_sub, use_cin, known, wr_res, narrow;

  assign op      = alu_op_e'(op_code);
  assign known   = (op_code <= 4'(OP_SEXT));
  assign is_sub  = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign use_cin = (op == OP_ADDC) || (op == OP_SUBC);
  assign narrow  = byte_mode && (op != OP_SEXT);
  assign wr_res  = op_valid && known && (op != OP_CMP);

  logic [WIDTH-1:0] sum_w [2];
  logic [1:0]       cy_w, ov_w;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_lane
      localparam int LW = (g == 0) ? WIDTH : HALF;
      logic [LW-1:0] s;
      alu_addsub #(.W(LW)) u_as (
        .a   (opnd_a[LW-1:0]),
        .b   (opnd_b[LW-1:0]),
        .sub (is_sub),
        .cin (use_cin & carry_in),
        .sum (s),
        .cy  (cy_w[g]),
        .ov  (ov_w[g])
      );
      always_comb begin
        sum_w[g] = '0;
        sum_w[g][LW-1:0] = s;
      end
    end
  endgenerate

  logic [WIDTH-1:0] full_r, res_n;
  logic             c_n, v_n, x_n, arith;
  alu_flags_t       f_n;

  always_comb begin
    arith = 1'b0;
    x_n   = 1'b0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        arith  = 1'b1;
        full_r = narrow ? sum_w[1] : sum_w[0];
      end
      OP_AND:  full_r = opnd_a & opnd_b;
      OP_OR:   full_r = opnd_a | opnd_b;
      OP_XOR:  full_r = opnd_a ^ opnd_b;
      OP_MOV:  full_r = opnd_b;
      OP_SEXT: begin
        full_r = {{(WIDTH-HALF){opnd_b[HALF-1]}}, opnd_b[HALF-1:0]};
        x_n    = opnd_b[HALF-1];
      end
      default: full_r = '0;
    endcase
    c_n = arith && (narrow ? cy_w[1] : cy_w[0]);
    v_n = arith && (narrow ? ov_w[1] : ov_w[0]);
    if (narrow) begin
      res_n = {opnd_a[WIDTH-1:HALF], full_r[HALF-1:0]};
      f_n.ng = full_r[HALF-1];
      f_n.zr = (full_r[HALF-1:0] == '0);
    end else begin
      res_n = full_r;
      f_n.ng = full_r[WIDTH-1];
      f_n.zr = (full_r == '0);
    end
    f_n.cy = c_n;
    f_n.ov = v_n;
    f_n.sx = x_n;
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (wr_res) result <= res_n;
  end

  logic [NF-1:0] shadow;

  alu_flag_bank #(.NF(NF)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .upd      (op_valid && known),
    .upd_val  (f_n),
    .save     (flag_save),
    .restore  (flag_restore),
    .flags_q  (flags),
    .shadow_q (shadow)
  );

  // R6: compare leaves the result untouched
  p_cmp_keeps_result_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd7) |=> $stable(result));
  // R4: upper byte follows operand A in byte mode
  p_byte_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && byte_mode && op_code <= 4'd8 && op_code != 4'd7)
      |=> result[WIDTH-1:HALF] == $past(opnd_a[WIDTH-1:HALF]));
  // R5: logical operations clear carry and overflow
  p_logic_clears_cv_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !flag_restore && op_code >= 4'd4 && op_code <= 4'd6)
      |=> (flags[2] == 1'b0 && flags[3] == 1'b0));
  // R9: idle cycles keep the result
  p_idle_result_r9: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code > 4'd9) |=> $stable(result));
  // R8: sign-extension flag mirrors bit 7 of the result
  p_sext_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !flag_restore && op_code == 4'd9)
      |=> flags[4] == result[HALF-1]);
endmodule

// File: tb/alu_flags_unit_test.sv
module alu_flags_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic        byte_mode = 1'b0;
  logic        carry_in = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic        flag_save = 1'b0;
  logic        flag_restore = 1'b0;
  logic [15:0] result;
  logic [4:0]  flags;

  int checks = 0;
  int failures = 0;
  int m_res = 0;
  int m_flg = 0;
  int m_sh = 0;

  always #4 clk = ~clk;

  alu_flags_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .byte_mode(byte_mode), .carry_in(carry_in), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .flag_save(flag_save), .flag_restore(flag_restore),
    .result(result), .flags(flags)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  // behavioural reference: returns {flags, result} packed in one int
  function automatic int model(int op, int bm, int ci, int a, int b);
    int w, msk, al, bl, s, r, n, z, c, v, x, sa, sb, sr, full;
    w = (bm != 0 && op != 9) ? 8 : 16;
    msk = (1 << w) - 1;
    al = a & msk;
    bl = b & msk;
    c = 0; v = 0; x = 0; r = 0;
    sa = (al >> (w - 1)) & 1;
    sb = (bl >> (w - 1)) & 1;
    case (op)
      0, 1: begin
        s = al + bl + ((op == 1) ? ci : 0);
        r = s & msk; c = (s >> w) & 1;
        sr = (r >> (w - 1)) & 1;
        v = (sa == sb && sr != sa) ? 1 : 0;
      end
      2, 3, 7: begin
        s = al - bl - ((op == 3) ? ci : 0);
        r = s & msk; c = (s < 0) ? 1 : 0;
        sr = (r >> (w - 1)) & 1;
        v = (sa != sb && sr != sa) ? 1 : 0;
      end
      4: r = al & bl;
      5: r = al | bl;
      6: r = al ^ bl;
      8: r = bl;
      default: begin
        r = ((b & 8'h80) != 0) ? ((b & 8'hFF) | 16'hFF00) : (b & 8'hFF);
        x = (b >> 7) & 1;
      end
    endcase
    n = (r >> (w - 1)) & 1;
    z = (r == 0) ? 1 : 0;
    full = (w == 8) ? ((a & 16'hFF00) | r) : r;
    return ((x << 4 | v << 3 | c << 2 | z << 1 | n) << 16) | full;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (result !== m_res[15:0] || flags !== m_flg[4:0]) begin
      failures++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               tag, result, flags, m_res[15:0], m_flg[4:0]);
    end
  endtask

  task automatic step(string tag, bit v, int op, bit bm, bit ci,
                      int a, int b, bit sv = 0, bit rs = 0);
    int nf, nr, ns, pk;
    op_valid = v; op_code = op[3:0]; byte_mode = bm; carry_in = ci;
    opnd_a = a[15:0]; opnd_b = b[15:0]; flag_save = sv; flag_restore = rs;
    nf = m_flg; nr = m_res; ns = sv ? m_flg : m_sh;
    if (v && op <= 9) begin
      pk = model(op, bm, ci, a & 16'hFFFF, b & 16'hFFFF);
      nf = (pk >> 16) & 5'h1F;
      if (op != 7) nr = pk & 16'hFFFF;
    end
    if (rs) nf = m_sh;
    m_flg = nf; m_res = nr; m_sh = ns;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 16'h0 || flags !== 5'h0) begin
      failures++;
      $display("FAIL R11: result=%h flags=%b expected 0000/00000", result, flags);
    end
    rst = 1'b0;

    step("R1", 1, 0, 0, 0, 16'h1234, 16'h4321);
    step("R1", 1, 0, 0, 0, 16'hFFFF, 16'h0001);
    step("R1", 1, 2, 0, 0, 16'h0003, 16'h0005);
    step("R1", 1, 2, 0, 0, 16'h0005, 16'h0005);
    step("R2", 1, 1, 0, 1, 16'hFFFE, 16'h0001);
    step("R2", 1, 0, 0, 1, 16'h0001, 16'h0001);
    step("R2", 1, 3, 0, 1, 16'h0005, 16'h0005);
    step("R2", 1, 2, 0, 1, 16'h0005, 16'h0005);
    step("R3", 1, 0, 0, 0, 16'h7FFF, 16'h0001);
    step("R3", 1, 2, 0, 0, 16'h8000, 16'h0001);
    step("R4", 1, 0, 1, 0, 16'hAB7F, 16'h0001);
    step("R4", 1, 0, 1, 0, 16'hCDFF, 16'h0001);
    step("R4", 1, 2, 1, 0, 16'h1280, 16'h3401);
    step("R4", 1, 3, 1, 1, 16'h0000, 16'h0000);
    step("R5", 1, 4, 0, 0, 16'hF0F0, 16'h0F0F);
    step("R5", 1, 5, 0, 0, 16'h8000, 16'h0001);
    step("R5", 1, 6, 1, 0, 16'h55AA, 16'h00AA);
    step("R6", 1, 7, 0, 0, 16'h0001, 16'h0002);
    step("R6", 1, 7, 1, 0, 16'h0080, 16'h0080);
    step("R7", 1, 8, 0, 0, 16'h1111, 16'h8000);
    step("R7", 1, 8, 1, 0, 16'h9900, 16'hFF00);
    step("R8", 1, 9, 0, 0, 16'h0000, 16'h1280);
    step("R8", 1, 9, 1, 0, 16'h0000, 16'hAB7F);
    step("R8", 1, 0, 0, 0, 16'h0001, 16'h0001);
    step("R9", 0, 0, 0, 0, 16'hFFFF, 16'hFFFF);
    step("R9", 1, 12, 0, 0, 16'hFFFF, 16'hFFFF);
    step("R10", 1, 2, 0, 0, 16'h0000, 16'h0001, 0, 0);
    step("R10", 1, 4, 0, 0, 16'h0000, 16'h0000, 1, 0);
    step("R10", 1, 0, 0, 0, 16'h7FFF, 16'h7FFF, 0, 1);
    step("R10", 0, 0, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 11);
      step("R1", $urandom_range(0, 7) != 0, op, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 65535),
           $urandom_range(0, 65535), $urandom_range(0, 15) == 0,
           $urandom_range(0, 15) == 0);
    end
    finish_run();
  end
endmodule